// File: doc/BRIEF.md
# Configuration Link Programming Sequencer

This block is a hardware sequencer that loads a configuration image into a device reached through a register window on a configuration link. It talks to that window over a simple request/response register bus, with 32-bit data and one transaction in flight at a time. Each register address is a fixed offset added to a base-offset input. A single start pulse runs the whole bring-up:

- entry into configuration mode, with the clock select written before the mode bit;
- clock switches, each made of a clocks-per-word update and a burst of zero writes that flushes the remote sequencer;
- the ready handshake;
- a hand-off to a separate transmit block, which streams the image data through a start/done pair.

When the transmit block reports done, the sequencer tears the configuration mode down, checks the latched error flag, returns the device to its normal clocking and waits for it to report user mode.

Every status poll re-reads the status register at a fixed interval, derived from a 1 µs tick that a cycle prescaler produces. The number of reads is the timeout divided by the interval, rounded up. The outcome is given by a one-cycle done pulse and a 3-bit result code, which holds until the next start. The clocks-per-word ratio written before the data phase depends on the image type: compressed, encrypted, or plain.

Top module: `cfg_link_seq`

## Requirements
- R1: After reset, busy_o, done_o and xfer_start_o are 0, err_o is 0 and reg_req_o is 0.
- R2: If a status read (offset 0x1C) at start shows bit 20 (enable) clear, the run ends with err_o = 1 and no register write is issued.
- R3: If status bit 18 (ready) is already set at start, a full teardown (R8) runs before the setup steps: the first mode-register write is the clock switch of that teardown.
- R4: Setup performs two separate read-modify-writes of the mode register (offset 0x20). The first sets bit 1 (link-side clock). The second then sets bit 0 (configuration mode).
- R5: Every clock switch read-modify-writes the mode register with bits 15:8 set to 1 and clears nothing else. It then issues exactly DUMMY_WRITES (244) writes of zero to the data register (offset 0x28). A complete run has three clock switches, or four when R3 applies.
- R6: Setup sets bit 0 (config request) of the program register (offset 0x2C), then polls status bit 18 until it reads 1. The ready timeout of 10 µs at a 10 µs interval allows 1 read, after which the run ends with err_o = 2.
- R7: After the ready poll and a clock switch, setup sets bit 1 (start transfer) of the program register. It then writes the mode field 15:8 as 8 for a compressed image, 4 for an encrypted uncompressed image and 1 otherwise, and pulses xfer_start_o for one cycle.
- R8: After xfer_done_i, teardown clears program bit 1, then clears bit 0 in a separate write, then does a clock switch. It then polls status bit 18 until it reads 0, with the same limit and code as R6.
- R9: Teardown is followed by a read of the error-status register (offset 0x34). If bit 5 is set, the run ends with err_o = 3 and the mode register is not written again.
- R10: Otherwise bits 1 and 0 of the mode register are cleared in one write. Status is then polled until bits 24 and 21 both read 1. The timeout of 2000 µs allows 200 reads, after which err_o = 4.
- R11: Every register address equals base_i plus one of the offsets above. reg_req_o, reg_addr_o, reg_we_o and reg_wdata_o hold steady until reg_ack_i.
- R12: A run ends with a single-cycle done_o in the cycle busy_o falls. err_o is 0 on success and keeps its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, accepted while idle |
| img_compressed_i | input | 1 | Image is compressed (sampled at start) |
| img_encrypted_i | input | 1 | Image is encrypted (sampled at start) |
| base_i | input | 12 | Base offset added to every register offset |
| reg_req_o | output | 1 | Register request, held until acknowledged |
| reg_we_o | output | 1 | 1 for write, 0 for read |
| reg_addr_o | output | 12 | Register address |
| reg_wdata_o | output | 32 | Write data |
| reg_ack_i | input | 1 | Response strobe for the pending request |
| reg_rdata_i | input | 32 | Read data, valid with reg_ack_i |
| xfer_start_o | output | 1 | One-cycle pulse that starts the image transmit block |
| xfer_done_i | input | 1 | Transmit block finished |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| err_o | output | 3 | Result: 0 ok, 1 not enabled, 2 ready timeout, 3 latched config error, 4 user-mode timeout |

## Verification
The bench's device model records every register access as it is acknowledged. This gives write logs, counts of data writes and status reads, and a snapshot of the mode and program registers taken on the edge where xfer_start_o is seen. All of these have settled by the edge that raises done_o, which is one cycle after the response that decides the run. The bench samples on falling edges. It reads err_o on the falling edge where done_o is first seen high. One falling edge later it checks that done_o has dropped while err_o has held. Poll limits are checked as exact status-read counts, not as elapsed cycles.

// File: rtl/cls_pkg.sv
package cls_pkg;
  localparam int AW = 12;
  localparam int DW = 32;

  localparam logic [AW-1:0] OFS_STAT = 12'h01C;
  localparam logic [AW-1:0] OFS_MODE = 12'h020;
  localparam logic [AW-1:0] OFS_DATA = 12'h028;
  localparam logic [AW-1:0] OFS_PROG = 12'h02C;
  localparam logic [AW-1:0] OFS_ERRS = 12'h034;

  localparam int ST_RDY   = 18;
  localparam int ST_EN    = 20;
  localparam int ST_USER  = 21;
  localparam int ST_FCLK  = 24;
  localparam int MD_CFG   = 0;
  localparam int MD_LCLK  = 1;
  localparam int MD_NCLK  = 8;
  localparam int PG_REQ   = 0;
  localparam int PG_XFER  = 1;
  localparam int ES_LATCH = 5;

  localparam logic [DW-1:0] NCLK_MASK = 32'h0000_FF00;
  localparam logic [DW-1:0] USER_MASK = (32'd1 << ST_USER) | (32'd1 << ST_FCLK);

  localparam logic [4:0] PC_SETUP   = 5'd1;
  localparam logic [4:0] PC_TD      = 5'd10;
  localparam logic [4:0] PC_TD_POLL = 5'd13;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_NOEN = 3'd1, E_RDY_TO = 3'd2, E_LATCH = 3'd3, E_USER_TO = 3'd4
  } err_e;

  typedef enum logic [2:0] {
    K_CHKEN, K_RMW, K_CLKSW, K_RATIO, K_POLL, K_XFER, K_CHKERR, K_FIN
  } kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [AW-1:0]   ofs;
    logic [DW-1:0]   clr;
    logic [DW-1:0]   set;
    logic            want;
    logic            long_to;
  } uop_t;

  function automatic uop_t mk(input kind_e k, input logic [AW-1:0] o,
                              input logic [DW-1:0] c, input logic [DW-1:0] s,
                              input logic w, input logic l);
    uop_t u;
    u.kind = k; u.ofs = o; u.clr = c; u.set = s; u.want = w; u.long_to = l;
    return u;
  endfunction

  // Step list; the order of the steps is the handshake order.
  function automatic uop_t uop_at(input logic [4:0] pc);
    case (pc)
      5'd0:  return mk(K_CHKEN,  OFS_STAT, '0, '0, 1'b0, 1'b0);
      5'd1:  return mk(K_RMW,    OFS_MODE, '0, 32'd1 << MD_LCLK, 1'b0, 1'b0);
      5'd2:  return mk(K_RMW,    OFS_MODE, '0, 32'd1 << MD_CFG, 1'b0, 1'b0);
      5'd3:  return mk(K_CLKSW,  OFS_MODE, NCLK_MASK, 32'd1 << MD_NCLK, 1'b0, 1'b0);
      5'd4:  return mk(K_RMW,    OFS_PROG, '0, 32'd1 << PG_REQ, 1'b0, 1'b0);
      5'd5:  return mk(K_POLL,   OFS_STAT, '0, '0, 1'b1, 1'b0);
      5'd6:  return mk(K_CLKSW,  OFS_MODE, NCLK_MASK, 32'd1 << MD_NCLK, 1'b0, 1'b0);
      5'd7:  return mk(K_RMW,    OFS_PROG, '0, 32'd1 << PG_XFER, 1'b0, 1'b0);
      5'd8:  return mk(K_RATIO,  OFS_MODE, NCLK_MASK, '0, 1'b0, 1'b0);
      5'd9:  return mk(K_XFER,   OFS_STAT, '0, '0, 1'b0, 1'b0);
      5'd10: return mk(K_RMW,    OFS_PROG, 32'd1 << PG_XFER, '0, 1'b0, 1'b0);
      5'd11: return mk(K_RMW,    OFS_PROG, 32'd1 << PG_REQ, '0, 1'b0, 1'b0);
      5'd12: return mk(K_CLKSW,  OFS_MODE, NCLK_MASK, 32'd1 << MD_NCLK, 1'b0, 1'b0);
      5'd13: return mk(K_POLL,   OFS_STAT, '0, '0, 1'b0, 1'b0);
      5'd14: return mk(K_CHKERR, OFS_ERRS, '0, '0, 1'b0, 1'b0);
      5'd15: return mk(K_RMW,    OFS_MODE, (32'd1 << MD_LCLK) | (32'd1 << MD_CFG), '0, 1'b0, 1'b0);
      5'd16: return mk(K_POLL,   OFS_STAT, '0, '0, 1'b1, 1'b1);
      default: return mk(K_FIN,  OFS_STAT, '0, '0, 1'b0, 1'b0);
    endcase
  endfunction
endpackage

// File: rtl/cls_bus.sv
module cls_bus
  import cls_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_i,
  input  logic          cmd_we_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          rsp_o,
  output logic [DW-1:0] rsp_data_o
);
  logic          req_q, req_d;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_comb begin
    req_d = req_q;
    if (req_q && ack_i) req_d = 1'b0;
    if (cmd_i)          req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      req_q <= req_d;
      if (cmd_i) begin
        we_q    <= cmd_we_i;
        addr_q  <= cmd_addr_i;
        wdata_q <= cmd_wdata_i;
      end
    end
  end

  assign req_o      = req_q;
  assign we_o       = we_q;
  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;
  assign rsp_o      = req_q & ack_i;
  assign rsp_data_o = rdata_i;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_i) |=> (req_q && $stable(addr_q) && $stable(we_q) && $stable(wdata_q))); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i |-> (!req_q || ack_i)); // R11
endmodule

// File: rtl/cls_wait.sv
module cls_wait #(
  parameter int CLK_PER_US = 125,
  parameter int POLL_US    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic fire_o
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int UW = (POLL_US > 1) ? $clog2(POLL_US) : 1;

  logic          run_q, run_d;
  logic [PW-1:0] pre_q, pre_d;
  logic [UW-1:0] us_q, us_d;
  logic          tick;

  assign tick   = run_q && (pre_q == PW'(CLK_PER_US - 1));
  assign fire_o = tick && (us_q == UW'(POLL_US - 1));

  always_comb begin
    run_d = run_q;
    pre_d = pre_q;
    us_d  = us_q;
    if (arm_i) begin
      run_d = 1'b1;
      pre_d = '0;
      us_d  = '0;
    end else if (run_q) begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      if (tick) us_d = us_q + 1'b1;
      if (fire_o) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pre_q <= '0;
      us_q  <= '0;
    end else begin
      run_q <= run_d;
      pre_q <= pre_d;
      us_q  <= us_d;
    end
  end

  AST_FIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !arm_i) |=> !run_q); // R10
  AST_ARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |-> !run_q); // R6
endmodule

// File: rtl/cls_ctrl.sv
module cls_ctrl
  import cls_pkg::*;
#(
  parameter int DUMMY_WRITES = 244,
  parameter int POLL_US      = 10,
  parameter int RDY_TO_US    = 10,
  parameter int USR_TO_US    = 2000,
  parameter int RATIO_CMP    = 8,
  parameter int RATIO_ENC    = 4,
  parameter int RATIO_PLAIN  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cmp_i,
  input  logic          enc_i,
  input  logic [AW-1:0] base_i,
  output logic          cmd_o,
  output logic          cmd_we_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_wdata_o,
  input  logic          rsp_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          arm_o,
  input  logic          fire_i,
  output logic          xfer_start_o,
  input  logic          xfer_done_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    err_o
);
  localparam int RDY_TRIES = (RDY_TO_US + POLL_US - 1) / POLL_US;
  localparam int USR_TRIES = (USR_TO_US + POLL_US - 1) / POLL_US;
  localparam int MAX_TRIES = (RDY_TRIES > USR_TRIES) ? RDY_TRIES : USR_TRIES;
  localparam int RW        = $clog2(MAX_TRIES + 1);
  localparam int DCW       = $clog2(DUMMY_WRITES + 1);

  typedef enum logic [2:0] {PH_IDLE, PH_LAUNCH, PH_BUS, PH_PAUSE, PH_XFER} ph_e;
  typedef enum logic [1:0] {A_RD, A_WR, A_DUMMY} act_e;

  ph_e            ph_q, ph_d;
  act_e           act_q, act_d;
  logic [4:0]     pc_q, pc_d;
  logic [RW-1:0]  retry_q, retry_d;
  logic [DCW-1:0] dcnt_q, dcnt_d;
  logic           pre_q, pre_d;
  err_e           err_q, err_d;
  logic           busy_q, busy_d;
  logic           done_q, done_d;
  logic           xst_q, xst_d;
  logic [7:0]     ratio_q, ratio_d;
  uop_t           u;
  logic [DW-1:0]  set_v;
  logic           poll_hit;

  always_comb begin
    u        = uop_at(pc_q);
    set_v    = (u.kind == K_RATIO) ? {16'b0, ratio_q, 8'b0} : u.set;
    poll_hit = u.long_to ? ((rsp_data_i & USER_MASK) == USER_MASK)
                         : (rsp_data_i[ST_RDY] == u.want);
    pc_d = pc_q; ph_d = ph_q; act_d = act_q; retry_d = retry_q; dcnt_d = dcnt_q;
    pre_d = pre_q; err_d = err_q; busy_d = busy_q; ratio_d = ratio_q;
    done_d = 1'b0; xst_d = 1'b0; arm_o = 1'b0;
    cmd_o = 1'b0; cmd_we_o = 1'b0; cmd_addr_o = base_i + u.ofs; cmd_wdata_o = '0;
    case (ph_q)
      PH_IDLE: if (start_i) begin
        busy_d  = 1'b1;
        err_d   = E_NONE;
        pre_d   = 1'b0;
        pc_d    = '0;
        ratio_d = cmp_i ? 8'(RATIO_CMP) : (enc_i ? 8'(RATIO_ENC) : 8'(RATIO_PLAIN));
        ph_d    = PH_LAUNCH;
      end
      PH_LAUNCH: case (u.kind)
        K_XFER: begin xst_d = 1'b1; ph_d = PH_XFER; end
        K_FIN:  begin busy_d = 1'b0; done_d = 1'b1; ph_d = PH_IDLE; end
        default: begin
          cmd_o = 1'b1; act_d = A_RD; ph_d = PH_BUS;
          if (u.kind == K_POLL) retry_d = u.long_to ? RW'(USR_TRIES) : RW'(RDY_TRIES);
        end
      endcase
      PH_BUS: if (rsp_i) begin
        case (act_q)
          A_RD: case (u.kind)
            K_CHKEN: begin
              if (!rsp_data_i[ST_EN]) begin
                busy_d = 1'b0; done_d = 1'b1; err_d = E_NOEN; ph_d = PH_IDLE;
              end else if (rsp_data_i[ST_RDY]) begin
                pre_d = 1'b1; pc_d = PC_TD; ph_d = PH_LAUNCH;
              end else begin
                pc_d = pc_q + 5'd1; ph_d = PH_LAUNCH;
              end
            end
            K_POLL: begin
              if (poll_hit) begin
                ph_d = PH_LAUNCH;
                if (pc_q == PC_TD_POLL && pre_q) begin
                  pre_d = 1'b0; pc_d = PC_SETUP;
                end else begin
                  pc_d = pc_q + 5'd1;
                end
              end else if (retry_q <= RW'(1)) begin
                busy_d = 1'b0; done_d = 1'b1; ph_d = PH_IDLE;
                err_d  = u.long_to ? E_USER_TO : E_RDY_TO;
              end else begin
                retry_d = retry_q - 1'b1; arm_o = 1'b1; ph_d = PH_PAUSE;
              end
            end
            K_CHKERR: begin
              if (rsp_data_i[ES_LATCH]) begin
                busy_d = 1'b0; done_d = 1'b1; err_d = E_LATCH; ph_d = PH_IDLE;
              end else begin
                pc_d = pc_q + 5'd1; ph_d = PH_LAUNCH;
              end
            end
            default: begin
              cmd_o = 1'b1; cmd_we_o = 1'b1;
              cmd_wdata_o = (rsp_data_i & ~u.clr) | set_v;
              act_d = A_WR;
            end
          endcase
          A_WR: begin
            if (u.kind == K_CLKSW) begin
              cmd_o = 1'b1; cmd_we_o = 1'b1; cmd_addr_o = base_i + OFS_DATA;
              act_d = A_DUMMY; dcnt_d = DCW'(DUMMY_WRITES - 1);
            end else begin
              pc_d = pc_q + 5'd1; ph_d = PH_LAUNCH;
            end
          end
          default: begin
            if (dcnt_q == '0) begin
              pc_d = pc_q + 5'd1; ph_d = PH_LAUNCH;
            end else begin
              cmd_o = 1'b1; cmd_we_o = 1'b1; cmd_addr_o = base_i + OFS_DATA;
              dcnt_d = dcnt_q - 1'b1;
            end
          end
        endcase
      end
      PH_PAUSE: if (fire_i) begin
        cmd_o = 1'b1; act_d = A_RD; ph_d = PH_BUS;
      end
      default: if (xfer_done_i) begin
        pc_d = pc_q + 5'd1; ph_d = PH_LAUNCH;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; act_q <= A_RD; pc_q <= '0; retry_q <= '0; dcnt_q <= '0;
      pre_q <= 1'b0; err_q <= E_NONE; busy_q <= 1'b0; done_q <= 1'b0;
      xst_q <= 1'b0; ratio_q <= '0;
    end else begin
      ph_q <= ph_d; act_q <= act_d; pc_q <= pc_d; retry_q <= retry_d; dcnt_q <= dcnt_d;
      pre_q <= pre_d; err_q <= err_d; busy_q <= busy_d; done_q <= done_d;
      xst_q <= xst_d; ratio_q <= ratio_d;
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign xfer_start_o = xst_q;

  AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o && cmd_we_o && cmd_addr_o == base_i + OFS_DATA) |-> cmd_wdata_o == '0); // R5
  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xst_q |=> !xst_q); // R7
  AST_XFER_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    xst_q |-> busy_q); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R12
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q))); // R12
  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !done_q) |=> $stable(err_q) || busy_q); // R12
endmodule

// File: rtl/cfg_link_seq.sv
module cfg_link_seq
  import cls_pkg::*;
#(
  parameter int CLK_PER_US   = 125,
  parameter int DUMMY_WRITES = 244,
  parameter int POLL_US      = 10,
  parameter int RDY_TO_US    = 10,
  parameter int USR_TO_US    = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          img_compressed_i,
  input  logic          img_encrypted_i,
  input  logic [11:0]   base_i,
  output logic          reg_req_o,
  output logic          reg_we_o,
  output logic [11:0]   reg_addr_o,
  output logic [31:0]   reg_wdata_o,
  input  logic          reg_ack_i,
  input  logic [31:0]   reg_rdata_i,
  output logic          xfer_start_o,
  input  logic          xfer_done_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    err_o
);
  logic          rs1_q, rs2_q;
  logic          rst_s_n;
  logic          cmd, cmd_we, rsp, arm, fire;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata, rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s_n = rs2_q;

  cls_ctrl #(
    .DUMMY_WRITES(DUMMY_WRITES), .POLL_US(POLL_US),
    .RDY_TO_US(RDY_TO_US), .USR_TO_US(USR_TO_US)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .start_i(start_i),
    .cmp_i(img_compressed_i), .enc_i(img_encrypted_i), .base_i(base_i),
    .cmd_o(cmd), .cmd_we_o(cmd_we), .cmd_addr_o(cmd_addr), .cmd_wdata_o(cmd_wdata),
    .rsp_i(rsp), .rsp_data_i(rsp_data), .arm_o(arm), .fire_i(fire),
    .xfer_start_o(xfer_start_o), .xfer_done_i(xfer_done_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  cls_bus u_bus (
    .clk(clk), .rst_n(rst_s_n), .cmd_i(cmd), .cmd_we_i(cmd_we),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .req_o(reg_req_o), .we_o(reg_we_o), .addr_o(reg_addr_o), .wdata_o(reg_wdata_o),
    .ack_i(reg_ack_i), .rdata_i(reg_rdata_i), .rsp_o(rsp), .rsp_data_o(rsp_data)
  );

  cls_wait #(.CLK_PER_US(CLK_PER_US), .POLL_US(POLL_US)) u_wait (
    .clk(clk), .rst_n(rst_s_n), .arm_i(arm), .fire_o(fire)
  );
endmodule

// File: tb/sim_cfg_link_seq.sv
module sim_cfg_link_seq;
  localparam int DUMMY = 244;
  localparam int RDY_TRIES = (10 + 10 - 1) / 10;
  localparam int USR_TRIES = (2000 + 10 - 1) / 10;

  logic clk, rst_n, start, cmp, enc, ack, xdone;
  logic [11:0] base, addr;
  logic [31:0] wdata, rdata;
  logic req, we, xstart, busy, done;
  logic [2:0] err;

  cfg_link_seq #(.CLK_PER_US(2)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .img_compressed_i(cmp),
    .img_encrypted_i(enc), .base_i(base), .reg_req_o(req), .reg_we_o(we),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_ack_i(ack), .reg_rdata_i(rdata),
    .xfer_start_o(xstart), .xfer_done_i(xdone), .busy_o(busy), .done_o(done), .err_o(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int tests = 0, fails = 0;

  // device model configuration
  logic m_load, c_en, c_pre, c_rdead, c_stuck, c_udead, c_lerr;
  logic [31:0] mode_r, prog_r, snap_mode, snap_prog;
  logic [31:0] mode_log [16];
  logic [31:0] prog_log [16];
  int nmode, nprog, ndata, nnz, nstat, nbad, nxfer, xcnt;

  always @(posedge clk) begin
    logic [11:0] off;
    logic rdy, usr;
    if (m_load) begin
      mode_r <= '0; prog_r <= {31'b0, c_pre}; ack <= 1'b0; xdone <= 1'b0; xcnt <= 0;
      nmode <= 0; nprog <= 0; ndata <= 0; nnz <= 0; nstat <= 0; nbad <= 0; nxfer <= 0;
      rdata <= '0; snap_mode <= '0; snap_prog <= '0;
    end else begin
      xdone <= (xcnt == 1);
      if (xcnt != 0) xcnt <= xcnt - 1;
      if (xstart) begin
        nxfer <= nxfer + 1; snap_mode <= mode_r; snap_prog <= prog_r; xcnt <= 4;
      end
      if (req && !ack) begin
        ack <= 1'b1;
        off = addr - base;
        rdy = c_stuck | (~c_rdead & prog_r[0]);
        usr = ~c_udead & (mode_r[1:0] == 2'b00);
        rdata <= '0;
        if (we) begin
          case (off)
            12'h020: begin mode_r <= wdata; if (nmode < 16) mode_log[nmode] <= wdata; nmode <= nmode + 1; end
            12'h02C: begin prog_r <= wdata; if (nprog < 16) prog_log[nprog] <= wdata; nprog <= nprog + 1; end
            12'h028: begin ndata <= ndata + 1; if (wdata != 0) nnz <= nnz + 1; end
            default: nbad <= nbad + 1;
          endcase
        end else begin
          case (off)
            12'h01C: begin
              nstat <= nstat + 1;
              rdata <= (32'(c_en) << 20) | (32'(rdy) << 18) | (32'(usr) << 21) | (32'(usr) << 24);
            end
            12'h020: rdata <= mode_r;
            12'h02C: rdata <= prog_r;
            12'h034: rdata <= 32'(c_lerr) << 5;
            default: nbad <= nbad + 1;
          endcase
        end
      end else begin
        ack <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ratio_of(input logic c, input logic e);
    return c ? 32'd8 : (e ? 32'd4 : 32'd1);
  endfunction

  task automatic run(input logic en, input logic ic, input logic ie, input logic pre,
                     input logic rd, input logic st, input logic ud, input logic le,
                     input logic [11:0] b);
    int cyc;
    @(negedge clk);
    c_en = en; c_pre = pre; c_rdead = rd; c_stuck = st; c_udead = ud; c_lerr = le;
    base = b; cmp = ic; enc = ie; m_load = 1'b1;
    @(negedge clk);
    m_load = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      tests++; fails++;
      $display("FAIL R12 watchdog: done_o actual=0 expected=1");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] e_hold;
    rst_n = 1'b0; start = 1'b0; cmp = 1'b0; enc = 1'b0; base = '0;
    c_en = 1'b1; c_pre = 1'b0; c_rdead = 1'b0; c_stuck = 1'b0; c_udead = 1'b0; c_lerr = 1'b0;
    m_load = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_load = 1'b0;
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 req", 32'(req), 0);
    chk("R1 xfer_start", 32'(xstart), 0);

    // Sweep of image types, pre-started state and base offsets
    for (int i = 0; i < 8; i++) begin
      logic ic, ie, pr;
      logic [11:0] b;
      int nsw;
      ic = i[2]; ie = i[1]; pr = i[0];
      b = 12'(i % 3) << 8;
      nsw = pr ? 4 : 3;
      run(1'b1, ic, ie, pr, 1'b0, 1'b0, 1'b0, 1'b0, b);
      e_hold = err;
      chk("R12 success code", 32'(err), 0);
      chk("R5 dummy write count", 32'(ndata), 32'(DUMMY * nsw));
      chk("R5 dummy data zero", 32'(nnz), 0);
      chk("R7 ratio at transfer", snap_mode, (ratio_of(ic, ie) << 8) | 32'h3);
      chk("R7 program at transfer", snap_prog, 32'h3);
      chk("R7 one transfer", 32'(nxfer), 1);
      chk("R11 addresses in window", 32'(nbad), 0);
      chk("R10 final mode clear", mode_log[nmode - 1], 32'h100);
      chk("R10 status reads", 32'(nstat), pr ? 5 : 4);
      if (pr) begin
        chk("R3 teardown first mode write", mode_log[0], 32'h100);
        chk("R3 teardown prog writes", 32'(nprog), 6);
        chk("R3 first prog write clears xfer", prog_log[0], 32'h1);
        chk("R4 clock select first", mode_log[1], 32'h102);
        chk("R4 mode bit second", mode_log[2], 32'h103);
      end else begin
        chk("R4 clock select first", mode_log[0], 32'h2);
        chk("R4 mode bit second", mode_log[1], 32'h3);
        chk("R5 clock switch field", mode_log[2], 32'h103);
        chk("R6 config request", prog_log[0], 32'h1);
        chk("R8 teardown clears xfer", prog_log[2], 32'h1);
        chk("R8 teardown clears request", prog_log[3], 32'h0);
        chk("R8 prog write count", 32'(nprog), 4);
      end
      @(negedge clk);
      chk("R12 done one cycle", 32'(done), 0);
      chk("R12 err held", 32'(err), 32'(e_hold));
    end

    // R2 not enabled
    run(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h200);
    chk("R2 not-enabled code", 32'(err), 1);
    chk("R2 no writes", 32'(nmode + nprog + ndata), 0);
    @(negedge clk);
    chk("R12 error code held", 32'(err), 1);

    // R6 ready never rises
    run(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
    chk("R6 ready timeout code", 32'(err), 2);
    chk("R6 status reads", 32'(nstat), 32'(1 + RDY_TRIES));
    chk("R6 no transfer", 32'(nxfer), 0);
    chk("R6 one clock switch", 32'(ndata), 32'(DUMMY));

    // R8 ready stuck high: teardown poll times out
    run(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 12'h100);
    chk("R8 teardown timeout code", 32'(err), 2);
    chk("R8 teardown prog writes", 32'(nprog), 2);
    chk("R8 teardown status reads", 32'(nstat), 32'(1 + RDY_TRIES));
    chk("R8 teardown clock switch", 32'(ndata), 32'(DUMMY));

    // R9 latched configuration error
    run(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000);
    chk("R9 latched code", 32'(err), 3);
    chk("R9 mode write count", 32'(nmode), 6);
    chk("R9 mode not cleared", mode_log[5], 32'h103);

    // R10 user mode never reached
    run(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h200);
    chk("R10 user timeout code", 32'(err), 4);
    chk("R10 user poll reads", 32'(nstat), 32'(3 + USR_TRIES));
    chk("R10 mode cleared", mode_log[nmode - 1], 32'h100);

    // Recovery after errors
    run(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000);
    chk("R12 success after error", 32'(err), 0);
    chk("R7 encrypted ratio", snap_mode, 32'h403);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule